// File: doc/BRIEF.md
# Lane-Tagged Pipeline with Tag-Gated Data Registers

This block is a fixed-depth register pipeline. Each entry carries a data word and a one-hot lane tag. Every stage applies a small combinational transform to the word, and in this build that transform adds a constant. An all-zero tag marks an empty slot.

The tag registers move forward on every clock. The data registers of a stage load only when the tag arriving at that stage is live, meaning nonzero. In an empty slot the data is a don't-care, and the chosen don't-care is the value already held. Idle cycles therefore leave the data flops untouched, which saves switching power and keeps stale words from rippling down the chain.

The pipeline never stalls. A cancel mask with one bit per lane removes every entry of the named lanes from all stages in the same cycle, and the cancelled entries become empty slots. A tag with more than one bit set at the input raises an error flag.

Top module: `lgp_lane_pipe`

## Requirements
- R1: While reset is active, and on the first clock after reset is released, `lane_tag_o` is all zero and `multi_hot_o` is low.
- R2: Suppose an entry is presented with tag t and data d, and no cancel touches its lanes. Exactly STAGES rising edges later, `lane_tag_o` equals t and `data_o` equals (d + STAGES*STEP) modulo 2^WIDTH.
- R3: An all-zero input tag yields an all-zero `lane_tag_o` exactly STAGES edges later.
- R4: While `lane_tag_o` is zero, `data_o` keeps the value it had on the previous cycle. The data registers do not change in empty slots.
- R5: If bit j of `cancel_i` is high in a cycle, bit j is cleared from the tag of every entry in flight at the next edge. An entry whose tag is cleared completely never reaches the output, and bit j of `lane_tag_o` is low after that edge.
- R6: A fully cancelled entry loads no data register. Once it would have reached the output, `data_o` still holds the last live result.
- R7: `multi_hot_o` is high in the cycle after the input tag has two or more bits set, and low in the cycle after it has zero or one bit set.
- R8: Entries presented on consecutive cycles leave on consecutive cycles in the same order. Throughput is one entry per clock and nothing stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lane_tag_i | input | LANES | One-hot lane tag of the incoming entry; zero means no entry |
| data_i | input | WIDTH | Data word of the incoming entry |
| cancel_i | input | LANES | Per-lane cancel mask applied to all stages |
| lane_tag_o | output | LANES | Lane tag leaving the last stage |
| data_o | output | WIDTH | Data word held in the last stage |
| multi_hot_o | output | 1 | Registered flag for an input tag with more than one bit set |

## Verification
The bench builds the block with STAGES=3, LANES=4, WIDTH=8 and STEP=37. A three-stage chain is deep enough for a cancel to catch an entry in the middle stage while others sit before and after it. The 8-bit word with a step of 37 wraps the sum within one pass, so modular truncation is exercised. Four lanes allow every single-lane tag, multi-hot tags, and cancel masks that cover some lanes in flight but not others.

// File: rtl/lgp_pkg.sv
package lgp_pkg;
  localparam int unsigned MAX_LANES = 32;

  function automatic logic more_than_one(input logic [MAX_LANES-1:0] v);
    return (v & (v - 1'b1)) != '0;
  endfunction
endpackage

// File: rtl/lgp_rst_sync.sv
module lgp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/lgp_stage.sv
module lgp_stage #(
  parameter int unsigned LANES = 4,
  parameter int unsigned WIDTH = 16,
  parameter int unsigned STEP  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] tag_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [LANES-1:0] kill_i,
  output logic [LANES-1:0] tag_o,
  output logic [WIDTH-1:0] data_o
);
  localparam logic [WIDTH-1:0] StepW = WIDTH'(STEP);

  logic [LANES-1:0] tag_d, tag_q;
  logic [WIDTH-1:0] sum_d, data_q;
  logic             load_en;

  // next state: cancelled lanes drop out, data loads only behind a live tag
  always_comb begin
    tag_d   = tag_i & ~kill_i;
    load_en = |tag_d;
    sum_d   = data_i + StepW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tag_q <= '0;
    else         tag_q <= tag_d;
  end

  always_ff @(posedge clk_i) begin
    if (load_en) data_q <= sum_d;
  end

  assign tag_o  = tag_q;
  assign data_o = data_q;
endmodule

// File: rtl/lgp_tag_check.sv
module lgp_tag_check #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] tag_i,
  output logic             err_o
);
  import lgp_pkg::*;

  logic err_d, err_q;

  always_comb err_d = more_than_one(MAX_LANES'(tag_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign err_o = err_q;
endmodule

// File: rtl/lgp_lane_pipe.sv
module lgp_lane_pipe #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 4,
  parameter int unsigned STEP   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_tag_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [LANES-1:0] cancel_i,
  output logic [LANES-1:0] lane_tag_o,
  output logic [WIDTH-1:0] data_o,
  output logic             multi_hot_o
);
  localparam int unsigned Links = STAGES + 1;

  logic             rst_sync_n;
  logic [LANES-1:0] tag_link  [Links];
  logic [WIDTH-1:0] data_link [Links];

  lgp_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  assign tag_link[0]  = lane_tag_i;
  assign data_link[0] = data_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    lgp_stage #(
      .LANES(LANES),
      .WIDTH(WIDTH),
      .STEP (STEP)
    ) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_sync_n),
      .tag_i (tag_link[s]),
      .data_i(data_link[s]),
      .kill_i(cancel_i),
      .tag_o (tag_link[s+1]),
      .data_o(data_link[s+1])
    );
  end

  lgp_tag_check #(.LANES(LANES)) u_chk_tag (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .tag_i (lane_tag_i),
    .err_o (multi_hot_o)
  );

  assign lane_tag_o = tag_link[STAGES];
  assign data_o     = data_link[STAGES];
endmodule

// File: rtl/lgp_lane_pipe_chk.sv
module lgp_lane_pipe_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LANES-1:0] lane_tag_i,
  input logic [LANES-1:0] cancel_i,
  input logic [LANES-1:0] lane_tag_o,
  input logic [WIDTH-1:0] data_o,
  input logic             multi_hot_o
);
  logic seen_live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen_live_q <= 1'b0;
    else if (|lane_tag_o) seen_live_q <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (lane_tag_o == '0 && !multi_hot_o));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_live_q && lane_tag_o == '0) |-> $stable(data_o));

  // R5
  cancel_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cancel_i) |=> ((lane_tag_o & $past(cancel_i)) == '0));

  // R7
  multi_hot_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(lane_tag_i) > 1) |=> multi_hot_o);

  // R7
  single_hot_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(lane_tag_i) <= 1) |=> !multi_hot_o);
endmodule

bind lgp_lane_pipe lgp_lane_pipe_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_lane_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_sync_n),
  .lane_tag_i (lane_tag_i),
  .cancel_i   (cancel_i),
  .lane_tag_o (lane_tag_o),
  .data_o     (data_o),
  .multi_hot_o(multi_hot_o)
);

// File: tb/test_lgp_lane_pipe.sv
module test_lgp_lane_pipe;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WIDTH  = 8;
  localparam int unsigned STAGES = 3;
  localparam int unsigned STEP   = 37;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LANES-1:0] tag_in = '0;
  logic [WIDTH-1:0] data_in = '0;
  logic [LANES-1:0] cancel = '0;
  logic [LANES-1:0] tag_out;
  logic [WIDTH-1:0] data_out;
  logic             err_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference: queue of in-flight entries, front is what the output shows
  logic [LANES-1:0] q_tag[$];
  logic [WIDTH-1:0] q_dat[$];
  logic [WIDTH-1:0] held = '0;
  bit               held_ok = 1'b0;
  bit               exp_err = 1'b0;

  always #10 clk = ~clk;

  lgp_lane_pipe #(
    .LANES(LANES), .WIDTH(WIDTH), .STAGES(STAGES), .STEP(STEP)
  ) i_lgp_lane_pipe (
    .clk_i(clk), .rst_ni(rst_n), .lane_tag_i(tag_in), .data_i(data_in),
    .cancel_i(cancel), .lane_tag_o(tag_out), .data_o(data_out),
    .multi_hot_o(err_out)
  );

  task automatic model_reset();
    q_tag.delete();
    q_dat.delete();
    for (int i = 0; i < STAGES; i++) begin
      q_tag.push_back('0);
      q_dat.push_back('0);
    end
    exp_err = 1'b0;
  endtask

  task automatic check(string req);
    checks++;
    if (tag_out !== q_tag[0]) begin
      fails++;
      $display("FAIL %s tag: actual %h expected %h", req, tag_out, q_tag[0]);
    end
    checks++;
    if (err_out !== exp_err) begin
      fails++;
      $display("FAIL %s flag: actual %b expected %b", req, err_out, exp_err);
    end
    if (held_ok) begin
      checks++;
      if (data_out !== held) begin
        fails++;
        $display("FAIL %s data: actual %h expected %h", req, data_out, held);
      end
    end
  endtask

  // called just after a falling edge: drive, advance model, check at next fall
  task automatic cyc(input logic [LANES-1:0] t, input logic [WIDTH-1:0] d,
                     input logic [LANES-1:0] c, input string req);
    int ones;
    tag_in = t; data_in = d; cancel = c;
    for (int i = 0; i < q_tag.size(); i++) q_tag[i] = q_tag[i] & ~c;
    q_tag.push_back(t & ~c);
    q_dat.push_back(WIDTH'(int'(d) + STAGES * STEP));
    void'(q_tag.pop_front());
    void'(q_dat.pop_front());
    if (q_tag[0] != '0) begin
      held = q_dat[0];
      held_ok = 1'b1;
    end
    ones = $countones(t);
    exp_err = (ones > 1);
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) cyc('0, 8'hEE, '0, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    idle(4, "R1 R3");

    // R2: each single lane, one at a time, wraps past 255
    for (int l = 0; l < LANES; l++) begin
      cyc(LANES'(1) << l, WIDTH'(8'h10 + 8'h40 * l), '0, "R2");
      idle(STAGES, "R2 R4");
    end

    // R8: back-to-back stream across lanes
    for (int k = 0; k < 8; k++) cyc(LANES'(1) << (k % LANES), WIDTH'(k * 29 + 3), '0, "R8");
    idle(STAGES + 1, "R3 R4");

    // R5 R6: cancel the middle-stage entry of lane 1
    cyc(4'b0001, 8'h11, '0, "R5");
    cyc(4'b0010, 8'h22, '0, "R5");
    cyc(4'b0100, 8'h33, '0, "R5");
    cyc('0, 8'h00, 4'b0010, "R5 R6");
    idle(STAGES + 1, "R6");

    // R5: cancel arriving with a new entry of the same lane
    cyc(4'b1000, 8'h5A, 4'b1000, "R5 R6");
    idle(STAGES + 1, "R6");

    // R5: cancel a lane that has nothing in flight
    cyc(4'b0001, 8'h7F, '0, "R5");
    cyc('0, 8'h00, 4'b0100, "R5");
    idle(STAGES, "R5 R2");

    // R7: multi-hot tags raise the flag, single and zero clear it
    cyc(4'b0011, 8'h44, '0, "R7");
    cyc(4'b1111, 8'h45, '0, "R7");
    cyc(4'b0100, 8'h46, '0, "R7");
    cyc('0, 8'h00, '0, "R7");
    idle(STAGES, "R7 R4");

    // R3 R4: long idle with changing junk data must not move the output
    for (int k = 0; k < 6; k++) cyc('0, WIDTH'(k * 53), '0, "R4");

    // R1: reset again in the middle of traffic
    cyc(4'b0010, 8'h99, '0, "R2");
    rst_n = 1'b0;
    model_reset();
    held_ok = 1'b0;
    tag_in = '0;
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    idle(3, "R1 R3");
    cyc(4'b0100, 8'hC8, '0, "R2");
    idle(STAGES, "R2 R4");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule